// File: doc/BRIEF.md
# Chainable Event Counter Unit

This unit holds four 32-bit event counters: two general-purpose counters and two counters meant for bus transactions. Each counter picks one line of an event bus through its own select field. While the selected line is high and the counter is enabled, the counter goes up by one on each clock. Software reaches the unit through a small register port: one control word and one value word for each counter.

A general-purpose counter can take over the bus counter with the same index as its upper half. The pair then acts as one wide counter. The bus counter stops counting its own events, and the top of the pair is limited to a parameter-set width. Every counter has a sticky overflow flag and no interrupt. A per-counter policy decides what happens after an overflow: the counter either freezes until software clears the flag or wraps and keeps counting. A shadow register captures the upper half when the lower half is read, so software gets a consistent wide value from two reads.

Top module: `evcnt_unit`

## Requirements
- R1: After reset every control word, every counter value and every overflow flag reads zero.
- R2: An enabled counter (control bit 0) goes up by one on each clock in which the event line named by control bits [6:4] is high. A disabled counter, or one whose selected line is low, holds its value.
- R3: Address bit 2 low selects a control word and high selects a value word, and address bits [1:0] pick the counter: 0 and 1 are the general-purpose counters, 2 and 3 the bus counters. Writing a value word preloads the counter. A control word reads back en, roll (bit 1), chain (bit 2), select and the flag (bit 8).
- R4: A write that addresses a counter's registers in the same cycle as one of its events drops that increment, and the written value stands.
- R5: When a counter increments past all-ones it becomes zero and its flag (control bit 8) sets. The flag stays set through idle cycles and through control writes with bit 8 low. It clears only when a control write has bit 8 high.
- R6: With roll (control bit 1) set, a counter whose flag is set keeps counting from zero.
- R7: With roll clear, a counter whose flag is set holds its value against events. After the flag is cleared, it resumes on the next event.
- R8: With chain (bit 2) set on general-purpose counter i, bus counter i+2 becomes its upper half and takes the carry when the lower half wraps.
- R9: While chained, the bus counter ignores its own enable and event, and its own flag is not changed by the pair.
- R10: The chained pair is CHAIN_W bits wide (default 48). The upper half keeps only CHAIN_W-32 bits, and preloads into it are cut to that width. When the whole pair wraps, both halves become zero and only the general-purpose flag sets. Its roll bit then governs the pair.
- R11: Reading the value of a chained general-purpose counter copies the upper half into a shadow register. While chained, reads of the bus counter's value return that shadow.
- R12: A control write with bit 9 high zeroes that counter, or the whole pair when written to a chained general-purpose counter. Bit 9 reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt | input | 8 | Event lines, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (latches the shadow on a chained low read) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |

## Verification
A wrong carry path or a wrong upper-half mask shows in the cycle after the lower half wraps, as a wrong upper value or a flag on the wrong counter. A lost sticky bit or a stop mode that fails to freeze shows on the next read of the control or value word. A shadow that was not latched shows as a stale upper half on the read that follows a low read. Because of that, the scenarios preload counters next to all-ones and read back right after a few events.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int CNT_W   = 32;
  localparam int SEL_W   = 3;
  localparam int NUM_EVT = 1 << SEL_W;

  // control word bit positions
  localparam int EN_B    = 0;
  localparam int ROLL_B  = 1;
  localparam int CHAIN_B = 2;
  localparam int SEL_LSB = 4;
  localparam int OVF_B   = 8;
  localparam int CLR_B   = 9;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             chain;
    logic             roll;
    logic             en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [CNT_W-1:0] w);
    ctrl_t c;
    c.en    = w[EN_B];
    c.roll  = w[ROLL_B];
    c.chain = w[CHAIN_B];
    c.sel   = w[SEL_LSB +: SEL_W];
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] ctrl_to_word(input ctrl_t c, input logic ovf);
    logic [CNT_W-1:0] w;
    w = '0;
    w[EN_B]              = c.en;
    w[ROLL_B]            = c.roll;
    w[CHAIN_B]           = c.chain;
    w[SEL_LSB +: SEL_W]  = c.sel;
    w[OVF_B]             = ovf;
    return w;
  endfunction
endpackage

// File: rtl/evcnt_evsel.sv
module evcnt_evsel #(
  parameter int SW = 3,
  localparam int N = 1 << SW
) (
  input  logic [N-1:0]  evt,
  input  logic [SW-1:0] sel,
  output logic          hit
);
  assign hit = evt[sel];
endmodule

// File: rtl/evcnt_half.sv
module evcnt_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic [W-1:0] mask,
  output logic [W-1:0] value_o,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] bump(input logic [W-1:0] v, input logic [W-1:0] m);
    return (v + 1'b1) & m;
  endfunction

  function automatic logic at_top(input logic [W-1:0] v, input logic [W-1:0] m);
    return (v & m) == m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (load)  cnt_q <= load_val & mask;
    else if (inc)   cnt_q <= bump(cnt_q, mask);
  end

  assign value_o = cnt_q & mask;
  assign wrap    = inc && at_top(cnt_q, mask);

  // R5: a wrapping increment leaves the half at zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr && !load) |=> (value_o == '0));
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int CHAIN_W = 48   // 48..64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata
);
  localparam int NCNT  = 4;
  localparam int NPAIR = NCNT / 2;
  localparam logic [CNT_W-1:0] FULL    = '1;
  localparam logic [CNT_W-1:0] HI_MASK = FULL >> (2*CNT_W - CHAIN_W);

  ctrl_t            ctrl_q  [NCNT];
  logic             ovf_q   [NCNT];
  logic             ovf_set [NCNT];
  logic             hit     [NCNT];
  logic             wr_ctrl [NCNT];
  logic             wr_val  [NCNT];
  logic             wr_any  [NCNT];
  logic [CNT_W-1:0] lo_val  [NPAIR];
  logic [CNT_W-1:0] hi_val  [NPAIR];
  logic [CNT_W-1:0] shadow_q[NPAIR];
  logic             chained [NPAIR];

  // per-counter control word and sticky flag
  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    assign wr_ctrl[k] = wr_en && !addr[2] && (addr[1:0] == 2'(k));
    assign wr_val[k]  = wr_en &&  addr[2] && (addr[1:0] == 2'(k));
    assign wr_any[k]  = wr_ctrl[k] || wr_val[k];

    evcnt_evsel #(.SW(SEL_W)) u_sel (
      .evt (evt),
      .sel (ctrl_q[k].sel),
      .hit (hit[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[k] <= '0;
        ovf_q[k]  <= 1'b0;
      end else begin
        if (wr_ctrl[k]) ctrl_q[k] <= ctrl_from_word(wdata);
        ovf_q[k] <= (ovf_q[k] && !(wr_ctrl[k] && wdata[OVF_B])) || ovf_set[k];
      end
    end

    // R5: flag is sticky unless cleared by a one in bit 8
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[k] && !(wr_ctrl[k] && wdata[OVF_B])) |=> ovf_q[k]);
  end

  // counter pairs: general-purpose i as low half, bus i+2 as high half
  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic             pair_touch, lo_inc, lo_wrap, own_hi, hi_inc, hi_wrap;
    logic             lo_clr, hi_clr;
    logic [CNT_W-1:0] hi_mask;

    assign chained[i]  = ctrl_q[i].chain;
    assign pair_touch  = wr_any[i] || (chained[i] && wr_any[i+2]);
    assign lo_inc      = ctrl_q[i].en && hit[i] && (ctrl_q[i].roll || !ovf_q[i]) && !pair_touch;
    assign own_hi      = !chained[i] && ctrl_q[i+2].en && hit[i+2]
                         && (ctrl_q[i+2].roll || !ovf_q[i+2]) && !wr_any[i+2];
    assign hi_inc      = chained[i] ? lo_wrap : own_hi;
    assign hi_mask     = chained[i] ? HI_MASK : FULL;
    assign lo_clr      = wr_ctrl[i] && wdata[CLR_B];
    assign hi_clr      = (wr_ctrl[i+2] && wdata[CLR_B]) || (chained[i] && lo_clr);

    evcnt_half #(.W(CNT_W)) u_lo (
      .clk (clk), .rst_n (rst_n), .clr (lo_clr), .load (wr_val[i]),
      .load_val (wdata), .inc (lo_inc), .mask (FULL),
      .value_o (lo_val[i]), .wrap (lo_wrap)
    );

    evcnt_half #(.W(CNT_W)) u_hi (
      .clk (clk), .rst_n (rst_n), .clr (hi_clr), .load (wr_val[i+2]),
      .load_val (wdata), .inc (hi_inc), .mask (hi_mask),
      .value_o (hi_val[i]), .wrap (hi_wrap)
    );

    assign ovf_set[i]   = chained[i] ? hi_wrap : lo_wrap;
    assign ovf_set[i+2] = !chained[i] && hi_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shadow_q[i] <= '0;
      else if (rd_en && chained[i] && addr == {1'b1, 2'(i)})
        shadow_q[i] <= hi_val[i];
    end

    // R4: a value write lands exactly, whatever the events did
    a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_val[i] |=> (lo_val[i] == $past(wdata)));

    // R7: a stopped counter with its flag set does not move
    a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[i] && !ctrl_q[i].roll && !pair_touch) |=> $stable(lo_val[i]));

    // R9: a chained upper half moves only on a carry or a write
    a_r9_chain_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (chained[i] && !lo_wrap && !wr_any[i] && !wr_any[i+2]) |=> $stable(hi_val[i]));

    // R11: after a chained low read, the high read returns the captured value
    a_r11_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && chained[i] && addr == {1'b1, 2'(i)}) |=>
      (!(chained[i] && addr == {1'b1, 2'(i+2)}) || rdata == $past(hi_val[i])));
  end

  always_comb begin
    if (!addr[2]) begin
      rdata = ctrl_to_word(ctrl_q[addr[1:0]], ovf_q[addr[1:0]]);
    end else begin
      case (addr[1:0])
        2'd0:    rdata = lo_val[0];
        2'd1:    rdata = lo_val[1];
        2'd2:    rdata = chained[0] ? shadow_q[0] : hi_val[0];
        default: rdata = chained[1] ? shadow_q[1] : hi_val[1];
      endcase
    end
  end
endmodule

// File: tb/evcnt_unit_tb.sv
`timescale 1ns/1ps
module evcnt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] EN = 32'h1, ROLL = 32'h2, CHAIN = 32'h4;
  localparam logic [31:0] OVF = 32'h100, CLR = 32'h200;

  always #2.5 clk = ~clk;

  evcnt_unit u_dut (
    .clk (clk), .rst_n (rst_n), .evt (evt), .wr_en (wr_en),
    .rd_en (rd_en), .addr (addr), .wdata (wdata), .rdata (rdata)
  );

  function automatic logic [31:0] sel(input int e);
    return 32'(e) << 4;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    @(negedge clk);
    evt = m;
    repeat (n) @(posedge clk);
    #1 evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset value", d, 32'h0);
    end
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(3'd0, EN | sel(1));
    rd(3'd0, d);
    check("R3 ctrl readback", d, EN | sel(1));
    pulse(8'h02, 5);
    pulse(8'h01, 3);
    rd(3'd4, d);
    check("R2 counts selected line only", d, 32'd5);
    pulse(8'hFF, 4);
    rd(3'd5, d);
    check("R2 disabled counter holds", d, 32'd0);
    wr(3'd4, 32'd1000);
    rd(3'd4, d);
    check("R3 preload", d, 32'd1000);
  endtask

  task automatic t_write_wins;
    logic [31:0] d;
    @(negedge clk);
    evt = 8'h02; addr = 3'd4; wdata = 32'd100; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; evt = '0;
    rd(3'd4, d);
    check("R4 write beats event", d, 32'd100);
  endtask

  task automatic t_roll;
    logic [31:0] d;
    wr(3'd2, EN | ROLL | sel(2));
    wr(3'd6, 32'hFFFF_FFFE);
    pulse(8'h04, 3);
    rd(3'd6, d);
    check("R6 roll keeps counting", d, 32'd1);
    rd(3'd2, d);
    check("R5 flag set on wrap", d & OVF, OVF);
    repeat (5) @(posedge clk);
    wr(3'd2, EN | ROLL | sel(2));
    rd(3'd2, d);
    check("R5 flag sticky", d & OVF, OVF);
    wr(3'd2, EN | ROLL | sel(2) | OVF);
    rd(3'd2, d);
    check("R5 flag cleared by one", d & OVF, 32'h0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(3'd1, EN | sel(3));
    wr(3'd5, 32'hFFFF_FFFF);
    pulse(8'h08, 4);
    rd(3'd5, d);
    check("R7 stop holds at zero", d, 32'd0);
    rd(3'd1, d);
    check("R7 flag set", d & OVF, OVF);
    wr(3'd1, EN | sel(3) | OVF);
    pulse(8'h08, 2);
    rd(3'd5, d);
    check("R7 resumes after clear", d, 32'd2);
  endtask

  task automatic t_chain;
    logic [31:0] d;
    wr(3'd2, EN | sel(2));
    wr(3'd0, EN | CHAIN | sel(0));
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd6, 32'd5);
    pulse(8'h01, 1);
    rd(3'd4, d);
    check("R8 low half wraps", d, 32'd0);
    rd(3'd6, d);
    check("R8 carry into high half", d, 32'd6);
    pulse(8'h04, 4);
    rd(3'd4, d);
    rd(3'd6, d);
    check("R9 bus ignores own event", d, 32'd6);
    rd(3'd2, d);
    check("R9 bus flag untouched", d & OVF, 32'h0);
    rd(3'd4, d);
    wr(3'd6, 32'd9);
    rd(3'd6, d);
    check("R11 shadow holds old high", d, 32'd6);
    rd(3'd4, d);
    rd(3'd6, d);
    check("R11 shadow refreshed", d, 32'd9);
  endtask

  task automatic t_chain_wrap;
    logic [31:0] d;
    wr(3'd6, 32'h0001_FFFF);
    rd(3'd4, d);
    rd(3'd6, d);
    check("R10 high preload trimmed", d, 32'h0000_FFFF);
    wr(3'd4, 32'hFFFF_FFFE);
    pulse(8'h01, 2);
    rd(3'd4, d);
    check("R10 pair wrap low", d, 32'd0);
    rd(3'd6, d);
    check("R10 pair wrap high", d, 32'd0);
    rd(3'd0, d);
    check("R10 pair flag on gp", d & OVF, OVF);
    rd(3'd2, d);
    check("R10 no flag on bus", d & OVF, 32'h0);
    pulse(8'h01, 3);
    rd(3'd4, d);
    check("R10 pair stops", d, 32'd0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(3'd0, EN | CHAIN | sel(0) | OVF);
    wr(3'd4, 32'd7);
    wr(3'd6, 32'd3);
    wr(3'd0, EN | CHAIN | sel(0) | CLR);
    rd(3'd0, d);
    check("R12 clear bit reads zero", d, EN | CHAIN | sel(0));
    rd(3'd4, d);
    check("R12 low cleared", d, 32'd0);
    rd(3'd6, d);
    check("R12 high cleared", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_count;
    t_write_wins;
    t_roll;
    t_stop;
    t_chain;
    t_chain_wrap;
    t_clear;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=%h exp=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule